// File: doc/BRIEF.md
# Four-Wide Register Rename Stage

This block renames a group of up to four instructions on every clock. Each instruction names two architected source registers and, optionally, one architected destination. Every destination receives a fresh physical register taken from a circular free list. Every source is translated through the architected-to-physical map. A source that names a register written by an earlier instruction of the same group takes that sibling's new physical register instead of the map entry. The twelve physical register numbers for the group appear on registered outputs one cycle after the group is accepted.

The block can save a snapshot of the map when it accepts a group. Each snapshot also holds the free-list read position and the group sequence stamp. A recovery request puts all three back in a single cycle, which discards the renames made since the snapshot. Registers released at commit come back through a one-register-per-cycle return port and are appended to the free list.

Top module: `rename_stage4`

## Requirements
- R1: When `in_valid` is high and `stall` is low, the group is accepted. On the next cycle `out_valid` is high and `out_stamp` carries the group sequence number. The sequence number is 0 for the first group after reset and rises by one for each accepted group. `out_valid` is low after any cycle in which no group was accepted.
- R2: A source operand that no earlier sibling in its group writes is translated to the map entry of its architected register as it stood before the group.
- R3: Each instruction with `in_wr_en` set and a nonzero destination takes the next free-list entry. Instructions are served in slot order, slot 0 first. Slots that do not allocate consume nothing, and the physical numbers handed out within one group are all different.
- R4: A source in slot i that names the destination of an allocating slot j < i gets the new physical register of the highest such j. An instruction never sees its own new destination in its own sources.
- R5: After a group is accepted, the map entry of each written architected register is the physical register allocated by the last slot in the group that writes it.
- R6: When fewer than four registers are free, a valid group is stalled as a whole. `stall` is high, and neither the map nor the free list changes.
- R7: Architected register 0 always translates to physical register 0. A destination of 0 allocates nothing and is reported as physical 0.
- R8: A register presented on the return port (`ret_valid` high, nonzero `ret_preg`) is appended to the tail of the free list. Returned registers are handed out again after every entry already free, in the order in which they were returned.
- R9: An accepted group with `ckpt_save` high stores, in slot `ckpt_id`, the map as it stands after the group, the free-list read position after its allocations, and the sequence number of the next group.
- R10: A cycle with `rec_valid` high restores map, free-list read position and sequence number from slot `rec_id` in that cycle. Any group presented in the same cycle is stalled. The next group sees the restored map and receives the registers allocated after the snapshot.
- R11: After reset, architected register n maps to physical n, the free list holds physical 32 to 63 in ascending order, and `out_valid` is low.
- R12: An instruction with `in_wr_en` low reports destination 0 and allocates nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A group is presented |
| in_wr_en | input | 4 | Per slot: instruction writes a destination |
| in_dst | input | 4x5 | Per slot architected destination |
| in_src_a | input | 4x5 | Per slot first architected source |
| in_src_b | input | 4x5 | Per slot second architected source |
| ckpt_save | input | 1 | Snapshot the state after this group |
| ckpt_id | input | 2 | Snapshot slot to write |
| rec_valid | input | 1 | Restore from a snapshot this cycle |
| rec_id | input | 2 | Snapshot slot to restore |
| ret_valid | input | 1 | A freed register is returned |
| ret_preg | input | 6 | Returned physical register |
| stall | output | 1 | Presented group is not accepted this cycle |
| out_valid | output | 1 | Renamed group is on the outputs |
| out_dst | output | 4x6 | Per slot physical destination |
| out_src_a | output | 4x6 | Per slot physical first source |
| out_src_b | output | 4x6 | Per slot physical second source |
| out_stamp | output | 8 | Sequence number of the renamed group |

## Verification
Two pairs of functions can land in the same cycle. A recovery can coincide with a group arriving. A register return can coincide with a group while the free count is below four. The bench drives the recovery together with a valid group and expects a stall, then checks that the following group reads the restored map and re-receives the registers allocated after the snapshot. It also drains the free list and then returns one register per cycle while a group waits. The reference model counts free entries before each cycle's return, so the stall must hold until four entries were already free at the start of a cycle, and the returned registers must come out in return order.

// File: rtl/rn_pkg.sv
package rn_pkg;
    parameter int ARCH_REGS = 32;
    parameter int PHYS_REGS = 64;
    parameter int GROUP     = 4;
    parameter int CKPTS     = 4;
    parameter int STAMP_W   = 8;

    localparam int AW        = $clog2(ARCH_REGS);
    localparam int PW        = $clog2(PHYS_REGS);
    localparam int PTRW      = PW + 1;
    localparam int CW        = $clog2(CKPTS);
    localparam int GW        = $clog2(GROUP);
    localparam int NW        = $clog2(GROUP + 1);
    localparam int INIT_FREE = PHYS_REGS - ARCH_REGS;

    typedef logic [AW-1:0]      arch_t;
    typedef logic [PW-1:0]      phys_t;
    typedef logic [PTRW-1:0]    ptr_t;
    typedef logic [CW-1:0]      ckid_t;
    typedef logic [STAMP_W-1:0] stamp_t;
    typedef logic [NW-1:0]      cnt_t;

    typedef struct packed {
        logic  wr;
        arch_t dst;
        arch_t src_a;
        arch_t src_b;
    } uop_t;

    function automatic logic claims_dst(uop_t u);
        return u.wr && (u.dst != '0);
    endfunction
endpackage

// File: rtl/rn_free_list.sv
module rn_free_list
    import rn_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   pop_en,
    input  cnt_t                   pop_n,
    input  logic                   push_en,
    input  phys_t                  push_reg,
    input  logic                   restore_en,
    input  ptr_t                   restore_head,
    output ptr_t                   head_q,
    output ptr_t                   free_cnt,
    output phys_t [GROUP-1:0]      peek
);
    phys_t slots [PHYS_REGS];
    ptr_t  tail_q;

    assign free_cnt = tail_q - head_q;

    for (genvar g = 0; g < GROUP; g++) begin : g_peek
        ptr_t pos;
        assign pos     = head_q + ptr_t'(g);
        assign peek[g] = slots[pos[PW-1:0]];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= ptr_t'(INIT_FREE);
            for (int k = 0; k < PHYS_REGS; k++) begin
                slots[k] <= (k < INIT_FREE) ? phys_t'(ARCH_REGS + k) : '0;
            end
        end else begin
            if (restore_en) begin
                head_q <= restore_head;
            end else if (pop_en) begin
                head_q <= head_q + ptr_t'(pop_n);
            end
            if (push_en) begin
                slots[tail_q[PW-1:0]] <= push_reg;
                tail_q                <= tail_q + ptr_t'(1);
            end
        end
    end
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table
    import rn_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  upd_en,
    input  logic  [GROUP-1:0]     wr_mask,
    input  arch_t [GROUP-1:0]     wr_arch,
    input  phys_t [GROUP-1:0]     wr_phys,
    input  logic                  save_en,
    input  ckid_t                 save_id,
    input  logic                  restore_en,
    input  ckid_t                 restore_id,
    input  arch_t [2*GROUP-1:0]   rd_arch,
    output phys_t [2*GROUP-1:0]   rd_phys
);
    phys_t map_q [ARCH_REGS];
    phys_t map_nx [ARCH_REGS];
    phys_t snap  [CKPTS][ARCH_REGS];

    // later slots overwrite earlier ones: last writer owns the entry
    always_comb begin
        map_nx = map_q;
        for (int i = 0; i < GROUP; i++) begin
            if (wr_mask[i]) begin
                map_nx[wr_arch[i]] = wr_phys[i];
            end
        end
    end

    for (genvar r = 0; r < 2*GROUP; r++) begin : g_rd
        assign rd_phys[r] = map_q[rd_arch[r]];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < ARCH_REGS; a++) begin
                map_q[a] <= phys_t'(a);
                for (int c = 0; c < CKPTS; c++) begin
                    snap[c][a] <= phys_t'(a);
                end
            end
        end else begin
            if (restore_en) begin
                map_q <= snap[restore_id];
            end else if (upd_en) begin
                map_q <= map_nx;
            end
            if (save_en && upd_en && !restore_en) begin
                snap[save_id] <= map_nx;
            end
        end
    end
endmodule

// File: rtl/rn_group_xlate.sv
module rn_group_xlate
    import rn_pkg::*;
(
    input  uop_t  [GROUP-1:0]     uops,
    input  phys_t [2*GROUP-1:0]   map_rd,
    input  phys_t [GROUP-1:0]     peek,
    output logic  [GROUP-1:0]     alloc,
    output phys_t [GROUP-1:0]     dst_p,
    output phys_t [GROUP-1:0]     src_a_p,
    output phys_t [GROUP-1:0]     src_b_p,
    output cnt_t                  alloc_n
);
    always_comb begin
        cnt_t                idx;
        logic  [GROUP-1:0]   al;
        phys_t [GROUP-1:0]   d;
        phys_t [GROUP-1:0]   a;
        phys_t [GROUP-1:0]   b;
        idx = '0;
        al  = '0;
        d   = '0;
        a   = '0;
        b   = '0;
        for (int i = 0; i < GROUP; i++) begin
            al[i] = claims_dst(uops[i]);
            a[i]  = map_rd[2*i];
            b[i]  = map_rd[2*i+1];
            // scan older siblings in order so the youngest older writer wins
            for (int j = 0; j < i; j++) begin
                if (al[j] && (uops[j].dst == uops[i].src_a)) a[i] = d[j];
                if (al[j] && (uops[j].dst == uops[i].src_b)) b[i] = d[j];
            end
            if (al[i]) begin
                d[i] = peek[idx[GW-1:0]];
                idx  = idx + cnt_t'(1);
            end
        end
        alloc   = al;
        dst_p   = d;
        src_a_p = a;
        src_b_p = b;
        alloc_n = idx;
    end
endmodule

// File: rtl/rename_stage4.sv
module rename_stage4
    import rn_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic  [GROUP-1:0]     in_wr_en,
    input  arch_t [GROUP-1:0]     in_dst,
    input  arch_t [GROUP-1:0]     in_src_a,
    input  arch_t [GROUP-1:0]     in_src_b,
    input  logic                  ckpt_save,
    input  ckid_t                 ckpt_id,
    input  logic                  rec_valid,
    input  ckid_t                 rec_id,
    input  logic                  ret_valid,
    input  phys_t                 ret_preg,
    output logic                  stall,
    output logic                  out_valid,
    output phys_t [GROUP-1:0]     out_dst,
    output phys_t [GROUP-1:0]     out_src_a,
    output phys_t [GROUP-1:0]     out_src_b,
    output stamp_t                out_stamp
);
    uop_t  [GROUP-1:0]   uops;
    arch_t [2*GROUP-1:0] rd_arch;
    phys_t [2*GROUP-1:0] rd_phys;
    phys_t [GROUP-1:0]   peek;
    logic  [GROUP-1:0]   alloc;
    phys_t [GROUP-1:0]   dst_p;
    phys_t [GROUP-1:0]   src_a_p;
    phys_t [GROUP-1:0]   src_b_p;
    cnt_t                alloc_n;
    ptr_t                head_q;
    ptr_t                free_cnt;
    logic                fire;
    stamp_t              stamp_q;
    ptr_t                ck_head  [CKPTS];
    stamp_t              ck_stamp [CKPTS];

    for (genvar g = 0; g < GROUP; g++) begin : g_uop
        assign uops[g].wr      = in_wr_en[g];
        assign uops[g].dst     = in_dst[g];
        assign uops[g].src_a   = in_src_a[g];
        assign uops[g].src_b   = in_src_b[g];
        assign rd_arch[2*g]    = in_src_a[g];
        assign rd_arch[2*g+1]  = in_src_b[g];
    end

    assign fire  = in_valid && !rec_valid && (free_cnt >= ptr_t'(GROUP));
    assign stall = in_valid && !fire;

    rn_free_list u_free (
        .clk          (clk),
        .rst          (rst),
        .pop_en       (fire),
        .pop_n        (alloc_n),
        .push_en      (ret_valid && (ret_preg != '0)),
        .push_reg     (ret_preg),
        .restore_en   (rec_valid),
        .restore_head (ck_head[rec_id]),
        .head_q       (head_q),
        .free_cnt     (free_cnt),
        .peek         (peek)
    );

    rn_map_table u_map (
        .clk        (clk),
        .rst        (rst),
        .upd_en     (fire),
        .wr_mask    (alloc),
        .wr_arch    (in_dst),
        .wr_phys    (dst_p),
        .save_en    (ckpt_save),
        .save_id    (ckpt_id),
        .restore_en (rec_valid),
        .restore_id (rec_id),
        .rd_arch    (rd_arch),
        .rd_phys    (rd_phys)
    );

    rn_group_xlate u_xlate (
        .uops    (uops),
        .map_rd  (rd_phys),
        .peek    (peek),
        .alloc   (alloc),
        .dst_p   (dst_p),
        .src_a_p (src_a_p),
        .src_b_p (src_b_p),
        .alloc_n (alloc_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stamp_q   <= '0;
            out_valid <= 1'b0;
            out_dst   <= '0;
            out_src_a <= '0;
            out_src_b <= '0;
            out_stamp <= '0;
            for (int c = 0; c < CKPTS; c++) begin
                ck_head[c]  <= '0;
                ck_stamp[c] <= '0;
            end
        end else begin
            if (rec_valid) begin
                stamp_q <= ck_stamp[rec_id];
            end else if (fire) begin
                stamp_q <= stamp_q + stamp_t'(1);
            end
            if (fire && ckpt_save) begin
                ck_head[ckpt_id]  <= head_q + ptr_t'(alloc_n);
                ck_stamp[ckpt_id] <= stamp_q + stamp_t'(1);
            end
            out_valid <= fire;
            if (fire) begin
                out_dst   <= dst_p;
                out_src_a <= src_a_p;
                out_src_b <= src_b_p;
                out_stamp <= stamp_q;
            end
        end
    end
endmodule

// File: rtl/rename_stage4_chk.sv
module rename_stage4_chk
    import rn_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              rec_valid,
    input logic              stall,
    input logic              out_valid,
    input phys_t [GROUP-1:0] out_dst,
    input ptr_t              free_cnt
);
    AST_OUT_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !stall) |=> out_valid); // R1

    AST_NO_SPURIOUS_OUT: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && !stall) |=> !out_valid); // R1

    AST_LOW_FREE_STALLS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (free_cnt < ptr_t'(GROUP))) |-> stall); // R6

    AST_FREE_BOUND: assert property (@(posedge clk) disable iff (rst)
        free_cnt <= ptr_t'(PHYS_REGS - 1)); // R8

    AST_RECOVERY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && rec_valid) |-> stall); // R10

    for (genvar i = 0; i < GROUP; i++) begin : g_i
        for (genvar j = i + 1; j < GROUP; j++) begin : g_j
            AST_DST_UNIQUE: assert property (@(posedge clk) disable iff (rst)
                (out_valid && (out_dst[i] != '0)) |-> (out_dst[i] != out_dst[j])); // R3
        end
    end
endmodule

bind rename_stage4 rename_stage4_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .rec_valid (rec_valid),
    .stall     (stall),
    .out_valid (out_valid),
    .out_dst   (out_dst),
    .free_cnt  (free_cnt)
);

// File: tb/test_rename_stage4.sv
`timescale 1ns/1ps
module test_rename_stage4;
    import rn_pkg::*;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                in_valid = 1'b0;
    logic  [GROUP-1:0]   in_wr_en = '0;
    arch_t [GROUP-1:0]   in_dst = '0;
    arch_t [GROUP-1:0]   in_src_a = '0;
    arch_t [GROUP-1:0]   in_src_b = '0;
    logic                ckpt_save = 1'b0;
    ckid_t               ckpt_id = '0;
    logic                rec_valid = 1'b0;
    ckid_t               rec_id = '0;
    logic                ret_valid = 1'b0;
    phys_t               ret_preg = '0;
    logic                stall;
    logic                out_valid;
    phys_t [GROUP-1:0]   out_dst;
    phys_t [GROUP-1:0]   out_src_a;
    phys_t [GROUP-1:0]   out_src_b;
    stamp_t              out_stamp;

    rename_stage4 i_rename_stage4 (.*);

    always #4 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // behavioural reference state
    int m_map [32];
    int m_fl  [64];
    int m_head, m_tail, m_stamp;
    int ck_map [4][32];
    int ck_head [4];
    int ck_stamp [4];
    int pend [$];

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cycle(input bit v, input bit [3:0] we, input int d[4], input int sa[4], input int sb[4],
                         input bit sv, input int sid, input bit rc, input int rid,
                         input bit rt, input int rr, input string tag);
        int cur [32];
        int ed [4];
        int ea [4];
        int eb [4];
        int disp [$];
        int k;
        bit efire;
        @(negedge clk);
        in_valid = v;
        for (int i = 0; i < 4; i++) begin
            in_wr_en[i] = we[i];
            in_dst[i]   = arch_t'(d[i]);
            in_src_a[i] = arch_t'(sa[i]);
            in_src_b[i] = arch_t'(sb[i]);
        end
        ckpt_save = sv; ckpt_id = ckid_t'(sid);
        rec_valid = rc; rec_id  = ckid_t'(rid);
        ret_valid = rt; ret_preg = phys_t'(rr);
        efire = v && !rc && ((m_tail - m_head) >= 4);
        cur = m_map;
        k = 0;
        for (int i = 0; i < 4; i++) begin
            ea[i] = cur[sa[i]];
            eb[i] = cur[sb[i]];
            ed[i] = 0;
            if (we[i] && d[i] != 0) begin
                ed[i] = m_fl[(m_head + k) % 64];
                disp.push_back(cur[d[i]]);
                cur[d[i]] = ed[i];
                k++;
            end
        end
        #1;
        chk(stall === (v && !efire), rc ? "R10" : "R6", "stall", int'(stall), int'(v && !efire));
        @(posedge clk);
        #1;
        chk(out_valid === efire, "R1", "out_valid", int'(out_valid), int'(efire));
        if (efire) begin
            chk(out_stamp == stamp_t'(m_stamp), "R1", "stamp", int'(out_stamp), m_stamp % 256);
            for (int i = 0; i < 4; i++) begin
                chk(out_dst[i] == phys_t'(ed[i]), tag, $sformatf("dst[%0d]", i), int'(out_dst[i]), ed[i]);
                chk(out_src_a[i] == phys_t'(ea[i]), tag, $sformatf("src_a[%0d]", i), int'(out_src_a[i]), ea[i]);
                chk(out_src_b[i] == phys_t'(eb[i]), tag, $sformatf("src_b[%0d]", i), int'(out_src_b[i]), eb[i]);
            end
        end
        if (rc) begin
            m_map   = ck_map[rid];
            m_head  = ck_head[rid];
            m_stamp = ck_stamp[rid];
            pend.delete();
        end else if (efire) begin
            m_map  = cur;
            m_head = m_head + k;
            foreach (disp[n]) pend.push_back(disp[n]);
            if (sv) begin
                ck_map[sid]   = cur;
                ck_head[sid]  = m_head;
                ck_stamp[sid] = m_stamp + 1;
            end
            m_stamp++;
        end
        if (rt && rr != 0) begin
            m_fl[m_tail % 64] = rr;
            m_tail++;
        end
    endtask

    task automatic grp(input bit [3:0] we, input int d[4], input int sa[4], input int sb[4], input string tag);
        cycle(1, we, d, sa, sb, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            chk(0, "R1", "watchdog expired", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        int rr;
        bit rt;
        for (int a = 0; a < 32; a++) begin
            m_map[a] = a;
            for (int c = 0; c < 4; c++) ck_map[c][a] = a;
        end
        for (int s = 0; s < 64; s++) m_fl[s] = (s < 32) ? 32 + s : 0;
        m_head = 0; m_tail = 32; m_stamp = 0;
        for (int c = 0; c < 4; c++) begin ck_head[c] = 0; ck_stamp[c] = 0; end

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(out_valid === 1'b0, "R11", "out_valid after reset", int'(out_valid), 0);
        chk(stall === 1'b0, "R11", "stall after reset", int'(stall), 0);

        // identity map and first free entries
        grp(4'b1111, '{9, 10, 11, 12}, '{13, 14, 15, 16}, '{17, 18, 19, 20}, "R11");
        // intra-group bypass, own dest not seen by own sources
        grp(4'b0111, '{1, 4, 1, 7}, '{2, 1, 1, 1}, '{3, 5, 4, 0}, "R4");
        // last writer in group owns the map entry
        grp(4'b0011, '{5, 5, 0, 0}, '{1, 4, 5, 6}, '{9, 12, 5, 7}, "R5");
        grp(4'b0000, '{0, 0, 0, 0}, '{5, 1, 4, 9}, '{5, 2, 3, 12}, "R5");
        // register 0 never allocates and always reads 0
        grp(4'b1111, '{0, 6, 0, 8}, '{0, 0, 6, 0}, '{6, 8, 0, 8}, "R7");
        // write enable low allocates nothing
        grp(4'b1010, '{2, 3, 2, 3}, '{2, 3, 2, 3}, '{3, 2, 3, 2}, "R12");
        grp(4'b1111, '{21, 22, 23, 24}, '{21, 22, 23, 24}, '{25, 26, 27, 28}, "R3");
        grp(4'b0000, '{0, 0, 0, 0}, '{7, 11, 15, 19}, '{23, 27, 30, 31}, "R2");

        // mixed traffic with returns of displaced registers
        for (int n = 0; n < 200; n++) begin
            int d[4];
            int sa[4];
            int sb[4];
            bit [3:0] we;
            for (int i = 0; i < 4; i++) begin
                d[i]  = $urandom_range(0, 7);
                sa[i] = $urandom_range(0, 7);
                sb[i] = $urandom_range(0, 9);
            end
            we = 4'($urandom);
            rt = (pend.size() > 0) && ($urandom_range(0, 1) == 1);
            rr = rt ? pend.pop_front() : 0;
            cycle($urandom_range(0, 9) < 8, we, d, sa, sb, 0, 0, 0, 0, rt, rr, "R2");
        end

        // drain the free list, then feed it back one register at a time
        for (int n = 0; n < 40 && (m_tail - m_head) >= 4; n++) begin
            grp(4'b1111, '{1, 2, 3, 4}, '{1, 2, 3, 4}, '{5, 6, 7, 8}, "R8");
        end
        grp(4'b1111, '{1, 2, 3, 4}, '{4, 3, 2, 1}, '{0, 0, 0, 0}, "R6");
        grp(4'b1111, '{1, 2, 3, 4}, '{4, 3, 2, 1}, '{0, 0, 0, 0}, "R6");
        for (int n = 0; n < 7; n++) begin
            rt = pend.size() > 0;
            rr = rt ? pend.pop_front() : 0;
            cycle(1, 4'b1111, '{5, 6, 7, 1}, '{1, 5, 6, 7}, '{2, 3, 4, 5}, 0, 0, 0, 0, rt, rr, "R8");
        end
        for (int n = 0; n < 12; n++) begin
            rt = pend.size() > 0;
            rr = rt ? pend.pop_front() : 0;
            cycle(0, 4'b0000, '{0, 0, 0, 0}, '{0, 0, 0, 0}, '{0, 0, 0, 0}, 0, 0, 0, 0, rt, rr, "R8");
        end

        // snapshot, speculate, then roll back with a group waiting
        cycle(1, 4'b0011, '{1, 2, 0, 0}, '{3, 1, 2, 4}, '{4, 5, 6, 7}, 1, 2, 0, 0, 0, 0, "R9");
        grp(4'b1111, '{1, 2, 3, 4}, '{1, 2, 3, 4}, '{1, 2, 3, 4}, "R9");
        grp(4'b0101, '{3, 0, 4, 0}, '{3, 4, 1, 2}, '{4, 3, 2, 1}, "R9");
        cycle(1, 4'b1111, '{5, 6, 7, 8}, '{1, 2, 3, 4}, '{5, 6, 7, 8}, 0, 0, 1, 2, 0, 0, "R10");
        grp(4'b1111, '{1, 3, 4, 2}, '{1, 2, 3, 4}, '{1, 2, 3, 4}, "R10");
        grp(4'b0000, '{0, 0, 0, 0}, '{1, 2, 3, 4}, '{5, 6, 7, 8}, "R10");

        cycle(0, 4'b0000, '{0, 0, 0, 0}, '{0, 0, 0, 0}, '{0, 0, 0, 0}, 0, 0, 0, 0, 0, 0, "R1");
        if (!finished) begin
            finished = 1;
            summary();
            $finish;
        end
    end
endmodule